// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block sits next to a CPU core and decides when the core's clock runs. A one-cycle sleep strobe from the core moves the controller into a light sleep state, but only when both low-power selection bits are clear. While asleep, the core clock is gated and its registers keep their contents. The peripheral clock keeps running. A qualified interrupt ends the sleep and raises a one-cycle request to start interrupt exception processing. No reset is sent to the core on that path.

Two asynchronous pins override the state machine: an active-low reset pin and an active-low standby pin. Both pass through a two-stage synchronizer. The standby pin wins over everything and stops both clocks. The reset pin wins over interrupts. A reset pulse is accepted only when it stays low for at least a programmable number of cycles. On an accepted release, the controller emits a one-cycle reset-exception start pulse and returns to run. A shorter pulse sends the controller back to the state it held before the pulse. The hardware-standby state can be left only through a valid reset pulse.

Top module: `sleep_pwr_ctrl`

## Requirements
- R1: After the asynchronous reset `arst_n` is released, the controller is in run: `cpu_clk_en_o`=1 and `per_clk_en_o`=1, and `hw_standby_o`, `irq_wake_o`, `rst_exc_start_o` and `bad_mode_o` are all 0.
- R2: A sleep strobe in run with `stby_sel`=0 and `lowspd_sel`=0 enters sleep on the next edge. Sleep means `cpu_clk_en_o`=0 and `per_clk_en_o`=1.
- R3: A sleep strobe in run with either selection bit at 1 leaves the controller in run. It also raises `bad_mode_o` for exactly one cycle.
- R4: In sleep, interrupt source i wakes the controller when `irq_req[i]`=1, `irq_en[i]`=1 and `irq_mask_all`=0. The wake gives `cpu_clk_en_o`=1 on the next edge and a one-cycle `irq_wake_o` pulse.
- R5: In sleep, a disabled request or a request while `irq_mask_all`=1 does not wake the controller. `nmi`=1 wakes it regardless of enables and mask.
- R6: A low level on `res_pin_n` forces the reset state, with `cpu_clk_en_o`=0. If the synchronized low lasted at least `rst_min_cyc` cycles, the release produces one `rst_exc_start_o` pulse and the controller returns to run.
- R7: A synchronized low on `res_pin_n` shorter than `rst_min_cyc` cycles gives no `rst_exc_start_o` pulse. The controller returns to the state it held before the pulse.
- R8: A low level on `stby_pin_n` forces hardware standby from any state: `hw_standby_o`=1 and both clock enables 0. This holds even when `res_pin_n` is low at the same time.
- R9: Hardware standby persists after `stby_pin_n` returns high. It is left only by a valid reset pulse (R6), and a short reset pulse returns it to standby.
- R10: Entering sleep and waking by interrupt never raise `rst_exc_start_o`.
- R11: A reset-pin low that becomes visible in the same cycle as a qualified interrupt wake takes priority. No `irq_wake_o` pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| arst_n | input | 1 | Asynchronous power-on reset of the controller flops, active low |
| sleep_stb | input | 1 | One-cycle sleep request from the core |
| stby_sel | input | 1 | Standby-select control bit; must be 0 for sleep |
| lowspd_sel | input | 1 | Low-speed-select control bit; must be 0 for sleep |
| irq_req | input | NUM_IRQ | Per-source interrupt requests |
| irq_en | input | NUM_IRQ | Per-source interrupt enables |
| irq_mask_all | input | 1 | Core masks every interrupt except NMI |
| nmi | input | 1 | Non-maskable interrupt |
| res_pin_n | input | 1 | Asynchronous reset pin, active low |
| stby_pin_n | input | 1 | Asynchronous standby pin, active low |
| rst_min_cyc | input | CNT_W | Minimum accepted reset-pin low width, in cycles |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| irq_wake_o | output | 1 | One-cycle request to start interrupt exception processing |
| rst_exc_start_o | output | 1 | One-cycle start of reset exception processing |
| hw_standby_o | output | 1 | Hardware standby indication |
| bad_mode_o | output | 1 | One-cycle flag: sleep strobe with a non-zero selection bit |

## Verification
The interrupt wake and the reset-pin entry can land on the same clock edge. The bench provokes this while the controller is asleep. It drives the reset pin low, lets the two synchronizer stages fill, and only then raises an enabled, unmasked interrupt, so that both reach the state logic in the same cycle. The outcome is judged by counting pulses. No wake pulse may appear, the CPU clock must stay off, and after a long enough release exactly one reset-exception pulse must appear. The standby pin and the reset pin falling together are judged the same way: hardware standby must be the only result.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_SLEEP  = 2'd1,
        ST_RESET  = 2'd2,
        ST_HWSTBY = 2'd3
    } pwr_state_e;

    // Clock-enable policy per state
    function automatic logic cpu_runs(pwr_state_e s);
        return s == ST_RUN;
    endfunction

    function automatic logic per_runs(pwr_state_e s);
        return s != ST_HWSTBY;
    endfunction

endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
    parameter int               WIDTH   = 2,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) stg_q[g] <= RST_VAL;
                else         stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/slp_wake_qual.sv
module slp_wake_qual #(
    parameter int NUM_IRQ = 4
) (
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               irq_mask_all,
    input  logic               nmi,
    output logic               wake_o
);

    logic [NUM_IRQ-1:0] live;

    genvar g;
    generate
        for (g = 0; g < NUM_IRQ; g++) begin : g_src
            assign live[g] = irq_req[g] & irq_en[g] & ~irq_mask_all;
        end
    endgenerate

    assign wake_o = nmi | (|live);

endmodule

// File: rtl/slp_rst_filter.sv
module slp_rst_filter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             low_i,
    input  logic [CNT_W-1:0] min_cyc_i,
    output logic             long_ok_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (low_i) begin
            cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    // cnt_q holds the length of the low run in the first cycle after it ends
    assign long_ok_o = cnt_q >= min_cyc_i;

endmodule

// File: rtl/sleep_pwr_ctrl.sv
module sleep_pwr_ctrl
    import slp_pkg::*;
#(
    parameter int NUM_IRQ = 4,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               arst_n,
    input  logic               sleep_stb,
    input  logic               stby_sel,
    input  logic               lowspd_sel,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               irq_mask_all,
    input  logic               nmi,
    input  logic               res_pin_n,
    input  logic               stby_pin_n,
    input  logic [CNT_W-1:0]   rst_min_cyc,
    output logic               cpu_clk_en_o,
    output logic               per_clk_en_o,
    output logic               irq_wake_o,
    output logic               rst_exc_start_o,
    output logic               hw_standby_o,
    output logic               bad_mode_o
);

    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        pwr_state_e st;
        pwr_state_e prior;
        logic       wake_p;
        logic       rexc_p;
        logic       bad_p;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_RUN, prior: ST_RUN,
                                 wake_p: 1'b0, rexc_p: 1'b0, bad_p: 1'b0};

    logic [1:0] pins_s;
    logic       res_s, stby_s;
    logic       wake;
    logic       long_ok;
    ctl_t       ctl_d, ctl_q;

    slp_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b11)
    ) u_pin_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .d_i    ({stby_pin_n, res_pin_n}),
        .q_o    (pins_s)
    );

    assign res_s  = pins_s[0];
    assign stby_s = pins_s[1];

    slp_wake_qual #(
        .NUM_IRQ (NUM_IRQ)
    ) u_wake (
        .irq_req      (irq_req),
        .irq_en       (irq_en),
        .irq_mask_all (irq_mask_all),
        .nmi          (nmi),
        .wake_o       (wake)
    );

    slp_rst_filter #(
        .CNT_W (CNT_W)
    ) u_rfilt (
        .clk       (clk),
        .arst_n    (arst_n),
        .low_i     (stby_s & ~res_s),
        .min_cyc_i (rst_min_cyc),
        .long_ok_o (long_ok)
    );

    // Priority: standby pin, then reset pin, then normal transitions
    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.wake_p = 1'b0;
        ctl_d.rexc_p = 1'b0;
        ctl_d.bad_p  = 1'b0;
        if (!stby_s) begin
            ctl_d.st = ST_HWSTBY;
        end else if (!res_s) begin
            if (ctl_q.st != ST_RESET) begin
                ctl_d.prior = ctl_q.st;
                ctl_d.st    = ST_RESET;
            end
        end else begin
            case (ctl_q.st)
                ST_RUN: begin
                    if (sleep_stb) begin
                        if (stby_sel || lowspd_sel) ctl_d.bad_p = 1'b1;
                        else                        ctl_d.st    = ST_SLEEP;
                    end
                end
                ST_SLEEP: begin
                    if (wake) begin
                        ctl_d.st     = ST_RUN;
                        ctl_d.wake_p = 1'b1;
                    end
                end
                ST_RESET: begin
                    if (long_ok) begin
                        ctl_d.st     = ST_RUN;
                        ctl_d.rexc_p = 1'b1;
                    end else begin
                        ctl_d.st = ctl_q.prior;
                    end
                end
                default: ctl_d.st = ST_HWSTBY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) ctl_q <= CTL_RST;
        else         ctl_q <= ctl_d;
    end

    assign cpu_clk_en_o    = cpu_runs(ctl_q.st);
    assign per_clk_en_o    = per_runs(ctl_q.st);
    assign hw_standby_o    = ctl_q.st == ST_HWSTBY;
    assign irq_wake_o      = ctl_q.wake_p;
    assign rst_exc_start_o = ctl_q.rexc_p;
    assign bad_mode_o      = ctl_q.bad_p;

    // R2: legal sleep strobe gates only the CPU clock
    a_r2_sleep_entry: assert property (@(posedge clk) disable iff (!arst_n)
        (cpu_clk_en_o && sleep_stb && !stby_sel && !lowspd_sel && stby_s && res_s)
        |=> (!cpu_clk_en_o && per_clk_en_o));

    // R3: illegal strobe keeps run and flags once
    a_r3_bad_mode: assert property (@(posedge clk) disable iff (!arst_n)
        (cpu_clk_en_o && sleep_stb && (stby_sel || lowspd_sel) && stby_s && res_s)
        |=> (bad_mode_o && cpu_clk_en_o));

    a_r3_bad_one_cycle: assert property (@(posedge clk) disable iff (!arst_n)
        bad_mode_o |=> !bad_mode_o);

    // R4: qualified wake from sleep
    a_r4_wake: assert property (@(posedge clk) disable iff (!arst_n)
        (ctl_q.st == ST_SLEEP && wake && stby_s && res_s)
        |=> (irq_wake_o && cpu_clk_en_o));

    // R5: unqualified interrupt leaves sleep untouched
    a_r5_refuse: assert property (@(posedge clk) disable iff (!arst_n)
        (ctl_q.st == ST_SLEEP && !wake) |=> !irq_wake_o);

    // R6: reset exception start is a single pulse
    a_r6_rexc_one_cycle: assert property (@(posedge clk) disable iff (!arst_n)
        rst_exc_start_o |=> !rst_exc_start_o);

    // R8: standby pin dominates
    a_r8_standby: assert property (@(posedge clk) disable iff (!arst_n)
        !stby_s |=> (hw_standby_o && !cpu_clk_en_o && !per_clk_en_o));

    // R10: sleep entry and wake never start reset processing
    a_r10_no_reset: assert property (@(posedge clk) disable iff (!arst_n)
        irq_wake_o |-> !rst_exc_start_o);

    // R11: reset pin beats a simultaneous wake
    a_r11_reset_first: assert property (@(posedge clk) disable iff (!arst_n)
        (stby_s && !res_s) |=> (!irq_wake_o && !cpu_clk_en_o));

endmodule

// File: tb/sleep_pwr_ctrl_tb.sv
module sleep_pwr_ctrl_tb;

    localparam int  NUM_IRQ  = 2;
    localparam int  CNT_W    = 4;
    localparam time CLK_PER  = 10ns;
    localparam int  MIN_CYC  = 3;

    logic               clk = 1'b0;
    logic               arst_n;
    logic               sleep_stb, stby_sel, lowspd_sel;
    logic [NUM_IRQ-1:0] irq_req, irq_en;
    logic               irq_mask_all, nmi;
    logic               res_pin_n, stby_pin_n;
    logic [CNT_W-1:0]   rst_min_cyc;
    logic               cpu_clk_en_o, per_clk_en_o, irq_wake_o;
    logic               rst_exc_start_o, hw_standby_o, bad_mode_o;

    int n_chk  = 0;
    int n_fail = 0;
    int n_wake = 0;
    int n_rexc = 0;
    bit done   = 0;

    always #(CLK_PER/2) clk = ~clk;

    sleep_pwr_ctrl #(.NUM_IRQ(NUM_IRQ), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .arst_n(arst_n), .sleep_stb(sleep_stb),
        .stby_sel(stby_sel), .lowspd_sel(lowspd_sel),
        .irq_req(irq_req), .irq_en(irq_en), .irq_mask_all(irq_mask_all),
        .nmi(nmi), .res_pin_n(res_pin_n), .stby_pin_n(stby_pin_n),
        .rst_min_cyc(rst_min_cyc),
        .cpu_clk_en_o(cpu_clk_en_o), .per_clk_en_o(per_clk_en_o),
        .irq_wake_o(irq_wake_o), .rst_exc_start_o(rst_exc_start_o),
        .hw_standby_o(hw_standby_o), .bad_mode_o(bad_mode_o)
    );

    // Pulse counters, sampled mid-cycle
    always @(negedge clk) begin
        if (arst_n && irq_wake_o)      n_wake++;
        if (arst_n && rst_exc_start_o) n_rexc++;
    end

    task automatic tick(int n = 1);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic go_sleep();
        sleep_stb = 1'b1;
        tick();
        sleep_stb = 1'b0;
    endtask

    task automatic wake_nmi();
        nmi = 1'b1;
        tick();
        nmi = 1'b0;
        tick();
    endtask

    // Low for len sampled cycles, then settle past the synchronizer
    task automatic res_pulse(int len);
        res_pin_n = 1'b0;
        tick(len);
        res_pin_n = 1'b1;
        tick(5);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int w0, r0;
        bit exp;
        arst_n = 1'b0; sleep_stb = 1'b0; stby_sel = 1'b0; lowspd_sel = 1'b0;
        irq_req = '0; irq_en = '0; irq_mask_all = 1'b0; nmi = 1'b0;
        res_pin_n = 1'b1; stby_pin_n = 1'b1; rst_min_cyc = CNT_W'(MIN_CYC);
        tick(3);
        arst_n = 1'b1;
        tick(3);

        // R1 reset state
        chk("R1 cpu_clk_en", cpu_clk_en_o, 1);
        chk("R1 per_clk_en", per_clk_en_o, 1);
        chk("R1 hw_standby", hw_standby_o, 0);
        chk("R1 pulses", irq_wake_o + rst_exc_start_o + bad_mode_o, 0);

        // R2/R3 sweep over both selection bits
        for (int m = 0; m < 4; m++) begin
            stby_sel   = m[0];
            lowspd_sel = m[1];
            go_sleep();
            chk("R2 cpu_clk_en after strobe", cpu_clk_en_o, (m == 0) ? 0 : 1);
            chk("R2 per_clk_en after strobe", per_clk_en_o, 1);
            chk("R3 bad_mode", bad_mode_o, (m == 0) ? 0 : 1);
            tick();
            chk("R3 bad_mode one cycle", bad_mode_o, 0);
            stby_sel = 1'b0; lowspd_sel = 1'b0;
            if (m == 0) wake_nmi();
        end

        // R4/R5/R10 exhaustive interrupt qualification sweep
        for (int p = 0; p < 64; p++) begin
            go_sleep();
            r0 = n_rexc;
            chk("R10 sleep entry no reset", rst_exc_start_o, 0);
            irq_req      = p[1:0];
            irq_en       = p[3:2];
            irq_mask_all = p[4];
            nmi          = p[5];
            exp = p[5] | (~p[4] & |(p[1:0] & p[3:2]));
            tick();
            chk(exp ? "R4 wake cpu_clk_en" : "R5 refused cpu_clk_en",
                cpu_clk_en_o, exp);
            chk(exp ? "R4 wake pulse" : "R5 no wake pulse", irq_wake_o, exp);
            irq_req = '0; irq_en = '0; irq_mask_all = 1'b0; nmi = 1'b0;
            tick();
            chk("R4 wake pulse one cycle", irq_wake_o, 0);
            if (!exp) wake_nmi();
            chk("R10 no reset pulse on wake", n_rexc - r0, 0);
        end

        // R6/R7 reset width sweep from run and from sleep
        for (int s = 0; s < 2; s++) begin
            for (int len = 1; len <= MIN_CYC + 2; len++) begin
                if (s == 1) go_sleep();
                r0 = n_rexc;
                res_pulse(len);
                if (len >= MIN_CYC) begin
                    chk("R6 one reset pulse", n_rexc - r0, 1);
                    chk("R6 back in run", cpu_clk_en_o, 1);
                end else begin
                    chk("R7 short pulse ignored", n_rexc - r0, 0);
                    chk("R7 prior state restored", cpu_clk_en_o, (s == 1) ? 0 : 1);
                    if (s == 1) wake_nmi();
                end
            end
        end

        // R6 cpu clock off while pin held low
        res_pin_n = 1'b0;
        tick(4);
        chk("R6 cpu_clk_en during reset", cpu_clk_en_o, 0);
        res_pin_n = 1'b1;
        tick(5);

        // R11 reset entry coincides with wake
        go_sleep();
        w0 = n_wake; r0 = n_rexc;
        res_pin_n = 1'b0;
        tick(2);
        irq_req = 2'b01; irq_en = 2'b01;
        tick();
        chk("R11 cpu_clk_en stays off", cpu_clk_en_o, 0);
        tick(MIN_CYC);
        res_pin_n = 1'b1;
        tick(5);
        irq_req = '0; irq_en = '0;
        chk("R11 no wake pulse", n_wake - w0, 0);
        chk("R11 one reset pulse", n_rexc - r0, 1);

        // R8 standby from sleep together with reset pin low
        go_sleep();
        stby_pin_n = 1'b0; res_pin_n = 1'b0;
        tick(4);
        chk("R8 hw_standby", hw_standby_o, 1);
        chk("R8 clocks off", cpu_clk_en_o + per_clk_en_o, 0);
        res_pin_n = 1'b1;
        tick(2);
        stby_pin_n = 1'b1;
        tick(5);
        // R9 persists, short pulse returns, valid pulse leaves
        chk("R9 standby persists", hw_standby_o, 1);
        r0 = n_rexc;
        res_pulse(MIN_CYC - 1);
        chk("R9 short pulse keeps standby", hw_standby_o, 1);
        chk("R9 short pulse no reset", n_rexc - r0, 0);
        res_pulse(MIN_CYC);
        chk("R9 valid pulse leaves standby", hw_standby_o, 0);
        chk("R9 run after standby", cpu_clk_en_o + per_clk_en_o, 2);
        chk("R9 one reset pulse", n_rexc - r0, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule